// File: doc/BRIEF.md
# Framing Word Error Monitor

This block sits behind a frame aligner that already delivers bytes together with their position inside the frame. At the first two positions of every frame it compares the received bytes against the fixed framing word, 0xF6 then 0x28, and produces one verdict per frame. It counts how many frames in a row carried a damaged framing word. From that run length it grades three alarms: errored frame, severely errored frame and out-of-frame.

A run of 2 bad frames raises the errored-frame alarm, a run of 4 raises the severely-errored alarm, and a run of 24 declares out-of-frame. When out-of-frame is declared, the block sends the aligner a single-cycle request to hunt for the frame boundary again. Out-of-frame then stays latched and frame verdicts are ignored until the aligner reports that sync has been found again. The run length is visible on an output port, so the surrounding logic can read the current state of the frame stream.

Top module: `frame_word_monitor`

## Requirements
- R1: While reset is held and after it is released, bad_run is 0 and err_frame, sev_err_frame, out_of_frame and reacq_req are all 0.
- R2: Only bytes with byte_vld=1 and byte_idx equal to 0 or 1 take part in the framing check. Bytes at any other index, or bytes with byte_vld=0, never change bad_run or the alarms, even when they carry 0xF6 or 0x28.
- R3: The byte at index 1 closes the verdict for its frame. The frame is bad if the last index-0 byte was not 0xF6 or the index-1 byte is not 0x28. The index-0 flag is consumed by every index-1 byte, so an index-1 byte that arrives without a fresh index-0 byte makes the frame bad. If the index-1 byte is sampled at clock edge k, bad_run takes its new value at edge k+1. A bad frame raises bad_run by one.
- R4: A good frame sets bad_run to 0 and clears err_frame and sev_err_frame, at the same edge.
- R5: err_frame is 1 exactly when bad_run is 2 or more.
- R6: sev_err_frame is 1 exactly when bad_run is 4 or more, and it never appears without err_frame.
- R7: out_of_frame rises at the edge where bad_run reaches 24. It then stays 1 until it is cleared as described in R10.
- R8: reacq_req is high for exactly one cycle, which is the first cycle in which out_of_frame reads 1, and it is not high at any other time.
- R9: While out_of_frame is 1, frame verdicts are ignored. bad_run stays at 24 and never goes above 24, and the alarms keep their values.
- R10: sync_acq sampled high while out_of_frame is 1 clears out_of_frame, bad_run and all alarms at that edge. sync_acq has no effect while out_of_frame is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | Byte strobe from the aligner |
| byte_idx | input | 10 | Position of the byte within the frame |
| byte_dat | input | 8 | Received byte |
| sync_acq | input | 1 | Aligner reports that the frame boundary has been found again |
| bad_run | output | 5 | Number of consecutive bad framing words, saturating at 24 |
| err_frame | output | 1 | Errored-frame alarm (run of 2 or more) |
| sev_err_frame | output | 1 | Severely-errored-frame alarm (run of 4 or more) |
| out_of_frame | output | 1 | Latched out-of-frame state (run of 24) |
| reacq_req | output | 1 | One-cycle request to the aligner to re-acquire |

## Verification
The bench drives frames whose first byte is wrong, whose second byte is wrong, or where both are wrong. A design that checked only one of the two bytes would miss a whole class of bad frames and would keep bad_run at zero.

It also places the framing word at later byte positions and on bytes with the strobe low. A monitor that searched the stream for the word instead of checking fixed positions would then clear the run by mistake.

The run is driven through 23, 24 and beyond. This exposes an off-by-one declaration point, a counter that wraps instead of saturating, and a re-acquire request that lasts longer than one cycle or repeats. Sync reports are sent both while the block is in frame and while it is out of frame, which catches a clear that fires when it should not or fails to drop the latched state.

// File: rtl/fwm_pkg.sv
package fwm_pkg;

    // One verdict per frame, produced when the second framing byte arrives
    typedef struct packed {
        logic evt;   // a frame verdict is available this cycle
        logic bad;   // the framing word of that frame was damaged
    } fwm_verdict_t;

    localparam logic [7:0] FWM_HDR0_DEF = 8'hF6;
    localparam logic [7:0] FWM_HDR1_DEF = 8'h28;

endpackage

// File: rtl/fwm_word_check.sv
module fwm_word_check
    import fwm_pkg::*;
#(
    parameter int          IDX_W = 10,
    parameter logic [7:0]  HDR0  = FWM_HDR0_DEF,
    parameter logic [7:0]  HDR1  = FWM_HDR1_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [7:0]       byte_dat,
    output fwm_verdict_t     verdict
);

    localparam logic [IDX_W-1:0] POS0 = IDX_W'(0);
    localparam logic [IDX_W-1:0] POS1 = IDX_W'(1);

    typedef struct packed {
        logic         hdr0_ok;
        fwm_verdict_t vd;
    } chk_state_t;

    chk_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.vd.evt = 1'b0;
        st_d.vd.bad = 1'b0;
        if (byte_vld && (byte_idx == POS0)) begin
            st_d.hdr0_ok = (byte_dat == HDR0);
        end
        if (byte_vld && (byte_idx == POS1)) begin
            st_d.vd.evt  = 1'b1;
            st_d.vd.bad  = !(st_q.hdr0_ok && (byte_dat == HDR1));
            st_d.hdr0_ok = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign verdict = st_q.vd;

endmodule

// File: rtl/fwm_run_grader.sv
module fwm_run_grader
    import fwm_pkg::*;
#(
    parameter int EF_RUN  = 2,
    parameter int SEF_RUN = 4,
    parameter int OOF_RUN = 24,
    parameter int CNT_W   = $clog2(OOF_RUN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fwm_verdict_t     verdict,
    input  logic             sync_acq,
    output logic [CNT_W-1:0] run_cnt,
    output logic             ef_alm,
    output logic             sef_alm,
    output logic             oof_alm,
    output logic             reacq
);

    localparam logic [CNT_W-1:0] EF_LIM  = CNT_W'(EF_RUN);
    localparam logic [CNT_W-1:0] SEF_LIM = CNT_W'(SEF_RUN);
    localparam logic [CNT_W-1:0] OOF_LIM = CNT_W'(OOF_RUN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ef;
        logic             sef;
        logic             oof;
        logic             req;
    } grade_state_t;

    grade_state_t gr_d, gr_q;

    always_comb begin
        gr_d     = gr_q;
        gr_d.req = 1'b0;
        if (gr_q.oof) begin
            // latched: only the aligner's sync report releases it
            if (sync_acq) begin
                gr_d = '0;
            end
        end else if (verdict.evt) begin
            if (verdict.bad) begin
                if (gr_q.cnt < OOF_LIM) begin
                    gr_d.cnt = gr_q.cnt + CNT_W'(1);
                end
            end else begin
                gr_d.cnt = '0;
            end
            gr_d.ef  = (gr_d.cnt >= EF_LIM);
            gr_d.sef = (gr_d.cnt >= SEF_LIM);
            if (gr_d.cnt == OOF_LIM) begin
                gr_d.oof = 1'b1;
                gr_d.req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gr_q <= '0;
        end else begin
            gr_q <= gr_d;
        end
    end

    assign run_cnt = gr_q.cnt;
    assign ef_alm  = gr_q.ef;
    assign sef_alm = gr_q.sef;
    assign oof_alm = gr_q.oof;
    assign reacq   = gr_q.req;

endmodule

// File: rtl/frame_word_monitor.sv
module frame_word_monitor
    import fwm_pkg::*;
#(
    parameter int          IDX_W   = 10,
    parameter logic [7:0]  HDR0    = FWM_HDR0_DEF,
    parameter logic [7:0]  HDR1    = FWM_HDR1_DEF,
    parameter int          EF_RUN  = 2,
    parameter int          SEF_RUN = 4,
    parameter int          OOF_RUN = 24,
    localparam int         CNT_W   = $clog2(OOF_RUN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [7:0]       byte_dat,
    input  logic             sync_acq,
    output logic [CNT_W-1:0] bad_run,
    output logic             err_frame,
    output logic             sev_err_frame,
    output logic             out_of_frame,
    output logic             reacq_req
);

    fwm_verdict_t verdict;

    fwm_word_check #(
        .IDX_W (IDX_W),
        .HDR0  (HDR0),
        .HDR1  (HDR1)
    ) u_check (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (byte_vld),
        .byte_idx (byte_idx),
        .byte_dat (byte_dat),
        .verdict  (verdict)
    );

    fwm_run_grader #(
        .EF_RUN  (EF_RUN),
        .SEF_RUN (SEF_RUN),
        .OOF_RUN (OOF_RUN),
        .CNT_W   (CNT_W)
    ) u_grade (
        .clk      (clk),
        .rst_n    (rst_n),
        .verdict  (verdict),
        .sync_acq (sync_acq),
        .run_cnt  (bad_run),
        .ef_alm   (err_frame),
        .sef_alm  (sev_err_frame),
        .oof_alm  (out_of_frame),
        .reacq    (reacq_req)
    );

endmodule

// File: rtl/fwm_checker.sv
module fwm_checker #(
    parameter int         IDX_W   = 10,
    parameter logic [7:0] HDR1    = 8'h28,
    parameter int         OOF_RUN = 24,
    parameter int         CNT_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_vld,
    input logic [IDX_W-1:0] byte_idx,
    input logic [7:0]       byte_dat,
    input logic             sync_acq,
    input logic [CNT_W-1:0] bad_run,
    input logic             err_frame,
    input logic             sev_err_frame,
    input logic             out_of_frame,
    input logic             reacq_req
);

    p_bad_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_idx == IDX_W'(1) && byte_dat != HDR1 && !out_of_frame)
        |=> ##1 ($past(out_of_frame) || bad_run == $past(bad_run) + CNT_W'(1)));

    p_sev_has_ef_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sev_err_frame |-> err_frame);

    p_oof_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_of_frame && !sync_acq) |=> out_of_frame);

    p_req_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reacq_req |-> $rose(out_of_frame));

    p_req_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reacq_req |=> !reacq_req);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_of_frame && !sync_acq) |=> $stable(bad_run));

    p_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_run <= CNT_W'(OOF_RUN));

    p_sync_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_of_frame && sync_acq)
        |=> (bad_run == '0 && !out_of_frame && !err_frame && !sev_err_frame));

endmodule

bind frame_word_monitor fwm_checker #(
    .IDX_W   (IDX_W),
    .HDR1    (HDR1),
    .OOF_RUN (OOF_RUN),
    .CNT_W   (CNT_W)
) u_fwm_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .byte_vld      (byte_vld),
    .byte_idx      (byte_idx),
    .byte_dat      (byte_dat),
    .sync_acq      (sync_acq),
    .bad_run       (bad_run),
    .err_frame     (err_frame),
    .sev_err_frame (sev_err_frame),
    .out_of_frame  (out_of_frame),
    .reacq_req     (reacq_req)
);

// File: tb/frame_word_monitor_test.sv
module frame_word_monitor_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       byte_vld;
    logic [9:0] byte_idx;
    logic [7:0] byte_dat;
    logic       sync_acq;
    logic [4:0] bad_run;
    logic       err_frame, sev_err_frame, out_of_frame, reacq_req;

    always #5 clk = ~clk;

    frame_word_monitor uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .byte_vld      (byte_vld),
        .byte_idx      (byte_idx),
        .byte_dat      (byte_dat),
        .sync_acq      (sync_acq),
        .bad_run       (bad_run),
        .err_frame     (err_frame),
        .sev_err_frame (sev_err_frame),
        .out_of_frame  (out_of_frame),
        .reacq_req     (reacq_req)
    );

    int checks = 0;
    int fails  = 0;
    int reacq_seen = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: a pending verdict, then the run and its grades
    int m_cnt;
    bit m_oof, m_req, m_pend, m_pbad, m_b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_oof = 0; m_req = 0; m_pend = 0; m_pbad = 0; m_b0 = 0;
        end else begin
            m_req = 0;
            if (m_oof) begin
                if (sync_acq) begin
                    m_cnt = 0; m_oof = 0;
                end
            end else if (m_pend) begin
                if (m_pbad) m_cnt = (m_cnt < 24) ? m_cnt + 1 : 24;
                else        m_cnt = 0;
                if (m_cnt == 24) begin
                    m_oof = 1; m_req = 1;
                end
            end
            m_pend = 0;
            if (byte_vld && byte_idx == 10'd0) m_b0 = (byte_dat == 8'hF6);
            if (byte_vld && byte_idx == 10'd1) begin
                m_pend = 1;
                m_pbad = !(m_b0 && byte_dat == 8'h28);
                m_b0   = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (reacq_req) reacq_seen++;
        if (rst_n) begin
            chk("R3/R4/R9 bad_run", bad_run, m_cnt);
            chk("R5 err_frame", err_frame, (m_cnt >= 2) ? 1 : 0);
            chk("R6 sev_err_frame", sev_err_frame, (m_cnt >= 4) ? 1 : 0);
            chk("R7 out_of_frame", out_of_frame, m_oof);
            chk("R8 reacq_req", reacq_req, m_req);
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            tick();
            byte_vld = 1'b0;
            byte_idx = '0;
            byte_dat = '0;
        end
    endtask

    // one frame of len bytes; decoy places the framing word at indices 2 and 3
    task automatic frame(input logic [7:0] h0, input logic [7:0] h1,
                         input int len, input bit decoy);
        for (int i = 0; i < len; i++) begin
            tick();
            byte_vld = 1'b1;
            byte_idx = 10'(i);
            if (i == 0)                byte_dat = h0;
            else if (i == 1)           byte_dat = h1;
            else if (decoy && i == 2)  byte_dat = 8'hF6;
            else if (decoy && i == 3)  byte_dat = 8'h28;
            else                       byte_dat = 8'(8'h40 + i);
        end
        idle(1);
    endtask

    task automatic pulse_sync();
        tick();
        sync_acq = 1'b1;
        tick();
        sync_acq = 1'b0;
    endtask

    initial begin
        #1_500_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; byte_vld = 1'b0; byte_idx = '0; byte_dat = '0; sync_acq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset bad_run", bad_run, 0);
        chk("R1 reset oof", out_of_frame, 0);
        #2;
        rst_n = 1'b1;
        idle(2);
        @(negedge clk);
        chk("R1 post-reset alarms", {err_frame, sev_err_frame, out_of_frame, reacq_req}, 0);

        frame(8'h00, 8'h28, 6, 0);   // first byte wrong
        frame(8'hF6, 8'h00, 6, 0);   // second byte wrong
        @(negedge clk);
        chk("R3 run after two bad", bad_run, 2);
        chk("R5 errored after two bad", err_frame, 1);
        chk("R6 no severe at two", sev_err_frame, 0);

        frame(8'hF6, 8'h28, 6, 0);
        @(negedge clk);
        chk("R4 good frame clears run", bad_run, 0);
        chk("R4 good frame clears errored", err_frame, 0);

        for (int k = 0; k < 4; k++) frame(8'hF6, 8'h27, 5, 0);
        @(negedge clk);
        chk("R6 severe after four", sev_err_frame, 1);

        pulse_sync();
        idle(1);
        @(negedge clk);
        chk("R10 sync ignored in frame", bad_run, 4);

        frame(8'h12, 8'h34, 6, 1);
        @(negedge clk);
        chk("R2 decoy word at later index", bad_run, 5);

        tick();
        byte_vld = 1'b0; byte_idx = 10'd0; byte_dat = 8'hF6;
        tick();
        byte_idx = 10'd1; byte_dat = 8'h28;
        idle(3);
        @(negedge clk);
        chk("R2 strobe-low word ignored", bad_run, 5);

        for (int k = 0; k < 18; k++) frame(8'hF7, 8'h29, 4, 0);
        @(negedge clk);
        chk("R7 no oof at 23", {30'd0, out_of_frame}, 0);
        chk("R3 run at 23", bad_run, 23);
        frame(8'h00, 8'h00, 4, 0);
        @(negedge clk);
        chk("R7 oof at 24", out_of_frame, 1);
        chk("R8 single request", reacq_seen, 1);

        for (int k = 0; k < 3; k++) frame(8'h00, 8'h11, 4, 0);
        for (int k = 0; k < 2; k++) frame(8'hF6, 8'h28, 4, 0);
        @(negedge clk);
        chk("R9 run saturated and held", bad_run, 24);
        chk("R9 oof held through good frames", out_of_frame, 1);
        chk("R8 no repeat request", reacq_seen, 1);

        pulse_sync();
        idle(1);
        @(negedge clk);
        chk("R10 sync clears run", bad_run, 0);
        chk("R10 sync clears alarms", {err_frame, sev_err_frame, out_of_frame}, 0);

        // mixed traffic with short runs
        for (int k = 0; k < 60; k++) begin
            frame((k % 3 == 0) ? 8'h00 : 8'hF6,
                  (k % 5 == 1) ? 8'h29 : 8'h28,
                  4 + (k % 4), (k % 2 == 1));
        end

        // second declaration with sync arriving while a frame is in flight
        for (int k = 0; k < 26; k++) frame(8'hF6, 8'hFF, 4, 0);
        tick();
        byte_vld = 1'b1; byte_idx = 10'd0; byte_dat = 8'h01;
        sync_acq = 1'b1;
        tick();
        byte_idx = 10'd1; byte_dat = 8'h02;
        sync_acq = 1'b0;
        idle(3);
        @(negedge clk);
        chk("R10 clear then new bad frame", bad_run, 1);
        chk("R8 two requests total", reacq_seen, 2);

        idle(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule